// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block gathers interrupt causes from internal sources into a 32-bit main status word. Each cause bit is latched on a hardware event and stays set until the host acknowledges it by writing a one to that bit. A 32-bit enable mask selects which causes may reach the single host interrupt line. A companion DMA status word latches per-channel receive and transmit events, a high-priority receive event and a DMA error. Each of these also sets a summary bit in the main word.

The host line can be held back by a coalescing timer. The timer counts in 32 µs units, and each unit is derived from the core clock by a prescaler parameter. A high-priority receive event skips the wait. A second byte of the control word programs a periodic generator that raises its own cause bit at a fixed interval.

The host reaches four 32-bit words through a plain write-enable, address and data port. Reads return data combinationally for the selected word.

Top module: `irq_coalesce_top`

## Requirements
- R1: After reset the main status, DMA status and mask read 0, the control word reads 0x0000_0040 (coalescing 0x40, periodic 0x00), and irq_o is low.
- R2: A host write to the main status (address 1) or DMA status (address 3) clears each bit written as 1. A bit written as 0 keeps its value.
- R3: When a hardware set and a host clear hit the same status bit in the same cycle, the bit is set afterwards.
- R4: The DMA status (address 3) latches only these inputs: bits 0 and 1 (transmit channels), bits 16 and 17 (receive channels), bit 30 (high-priority receive) and bit 31 (error). Any other dma_cause_i bit is dropped.
- R5: A DMA receive event (bit 16, 17 or 30) sets main bit 31. A DMA transmit event (bit 0 or 1) sets main bit 27. A DMA error (bit 31) sets main bit 29.
- R6: irq_o is low whenever the main status AND the mask (address 2) is zero.
- R7: With a coalescing value of 0, irq_o is high in every cycle in which the masked status is nonzero.
- R8: With a coalescing value N > 0, irq_o goes high after N unit ticks have passed since the masked status became nonzero. The timer restarts each time the masked status rises from zero. A unit tick occurs every TICK_DIV clock cycles.
- R9: While DMA status bit 30 is set and the masked status is nonzero, irq_o is high regardless of the coalescing timer.
- R10: A periodic value P > 0 (control bits 15:8) sets main bit 28 once every P unit ticks. P = 0 stops it. Any write to the control word restarts the periodic count.
- R11: Address 0 is the control word: bits 7:0 hold the coalescing value, bits 15:8 the periodic value, and bits 31:16 read 0. Address 2 is the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 2 | Word select: 0 control, 1 main status, 2 mask, 3 DMA status |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| hw_cause_i | input | 32 | Per-bit set pulses for the main status |
| dma_cause_i | input | 32 | Per-bit set pulses for the DMA status |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume that cause inputs act as single-cycle set requests. They also assume that host writes land on one word per cycle, so a mask or status write never coincides with a write to another word. The stimulus drives every pulse and write for exactly one cycle between clock edges. It leaves the inputs idle during timer waits, so each coalescing and periodic interval runs free of unrelated events. The behavioural model in the bench sees the same inputs and is compared with irq_o and the read data on every clock.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned VW = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_DMA  = 2'd3
  } reg_sel_e;

  // main status summary positions
  localparam int unsigned BIT_TX_SUM   = 27;
  localparam int unsigned BIT_PERIODIC = 28;
  localparam int unsigned BIT_ERR_SUM  = 29;
  localparam int unsigned BIT_RX_SUM   = 31;

  // DMA status positions
  localparam int unsigned DMA_TX0   = 0;
  localparam int unsigned DMA_TX1   = 1;
  localparam int unsigned DMA_RX0   = 16;
  localparam int unsigned DMA_RX1   = 17;
  localparam int unsigned DMA_HIPRI = 30;
  localparam int unsigned DMA_ERR   = 31;

  localparam logic [DW-1:0] DMA_TX_MASK  = (DW'(1) << DMA_TX0) | (DW'(1) << DMA_TX1);
  localparam logic [DW-1:0] DMA_RX_MASK  = (DW'(1) << DMA_RX0) | (DW'(1) << DMA_RX1)
                                         | (DW'(1) << DMA_HIPRI);
  localparam logic [DW-1:0] DMA_ERR_MASK = DW'(1) << DMA_ERR;
  localparam logic [DW-1:0] DMA_VALID    = DMA_TX_MASK | DMA_RX_MASK | DMA_ERR_MASK;

  localparam logic [VW-1:0] COAL_RESET = VW'(8'h40);
  localparam logic [VW-1:0] PER_RESET  = '0;
endpackage

// File: rtl/irq_unit_tick.sv
module irq_unit_tick #(
  parameter int unsigned DIV = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         armed_q;

  // set overrides a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      armed_q <= 1'b0;
    end else begin
      q_q     <= (q_q & ~clr_i) | set_i;
      armed_q <= 1'b1;
    end
  end

  assign q_o = q_q;

  assert_w1c_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((($past(q_q) & ~q_q) & ~$past(clr_i)) == '0));

  assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (($past(set_i) & ~q_q) == '0));
endmodule

// File: rtl/irq_periodic_gen.sv
module irq_periodic_gen #(
  parameter int unsigned VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [VW-1:0] period_i,
  input  logic          restart_i,
  output logic          evt_o
);
  logic [VW-1:0] cnt_q;
  logic [VW:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + (VW+1)'(1);
  assign evt_o = (period_i != '0) && tick_i && (nxt >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (restart_i || period_i == '0)    cnt_q <= '0;
    else if (tick_i)                         cnt_q <= evt_o ? '0 : nxt[VW-1:0];
  end
endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
  parameter int unsigned VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pending_i,
  input  logic [VW-1:0] limit_i,
  output logic          expired_o
);
  logic          pend_q;
  logic          exp_q;
  logic [VW-1:0] cnt_q;
  logic [VW:0]   nxt;
  logic          rise;

  assign rise = pending_i && !pend_q;
  assign nxt  = {1'b0, cnt_q} + (VW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pending_i;
      if (rise || !pending_i) begin
        exp_q <= 1'b0;
        cnt_q <= '0;
      end else if (!exp_q && tick_i) begin
        if (nxt >= {1'b0, limit_i}) exp_q <= 1'b1;
        else                        cnt_q <= nxt[VW-1:0];
      end
    end
  end

  assign expired_o = exp_q;

  assert_expire_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exp_q) |-> $past(tick_i));

  assert_expire_needs_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |-> $past(pending_i));
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
  import irq_coal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] hw_cause_i,
  input  logic [DW-1:0] dma_cause_i,
  output logic          irq_o
);
  logic ctrl_wr, stat_wr, mask_wr, dma_wr;

  always_comb begin
    ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);
    stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);
    mask_wr = reg_we_i && (reg_addr_i == ADDR_MASK);
    dma_wr  = reg_we_i && (reg_addr_i == ADDR_DMA);
  end

  logic [VW-1:0] coal_q, per_q;
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coal_q <= COAL_RESET;
      per_q  <= PER_RESET;
      mask_q <= '0;
    end else begin
      if (ctrl_wr) begin
        coal_q <= reg_wdata_i[VW-1:0];
        per_q  <= reg_wdata_i[2*VW-1:VW];
      end
      if (mask_wr) mask_q <= reg_wdata_i;
    end
  end

  logic tick;
  irq_unit_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  logic per_evt;
  irq_periodic_gen #(.VW(VW)) u_periodic (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .period_i  (per_q),
    .restart_i (ctrl_wr),
    .evt_o     (per_evt)
  );

  logic [DW-1:0] dma_ev, main_set, main_clr, dma_clr;
  logic [DW-1:0] stat_q, dma_q;

  always_comb begin
    dma_ev   = dma_cause_i & DMA_VALID;
    main_set = hw_cause_i;
    main_set[BIT_RX_SUM]   = main_set[BIT_RX_SUM]   | (|(dma_ev & DMA_RX_MASK));
    main_set[BIT_TX_SUM]   = main_set[BIT_TX_SUM]   | (|(dma_ev & DMA_TX_MASK));
    main_set[BIT_ERR_SUM]  = main_set[BIT_ERR_SUM]  | (|(dma_ev & DMA_ERR_MASK));
    main_set[BIT_PERIODIC] = main_set[BIT_PERIODIC] | per_evt;
    main_clr = stat_wr ? reg_wdata_i : '0;
    dma_clr  = dma_wr  ? reg_wdata_i : '0;
  end

  irq_cause_reg #(.W(DW)) u_main_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (main_set),
    .clr_i  (main_clr),
    .q_o    (stat_q)
  );

  irq_cause_reg #(.W(DW)) u_dma_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dma_ev),
    .clr_i  (dma_clr),
    .q_o    (dma_q)
  );

  logic masked_any, coal_exp;
  assign masked_any = |(stat_q & mask_q);

  irq_coal_timer #(.VW(VW)) u_coal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .pending_i (masked_any),
    .limit_i   (coal_q),
    .expired_o (coal_exp)
  );

  // high-priority receive skips the coalescing wait
  assign irq_o = masked_any && ((coal_q == '0) || coal_exp || dma_q[DMA_HIPRI]);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {{(DW-2*VW){1'b0}}, per_q, coal_q};
      ADDR_STAT: reg_rdata_o = stat_q;
      ADDR_MASK: reg_rdata_o = mask_q;
      default:   reg_rdata_o = dma_q;
    endcase
  end

  assert_mask_off_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && reg_wdata_i == '0) |=> !irq_o);

  assert_zero_coal_now_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[VW-1:0] == '0 && masked_any) |=> irq_o);

  assert_hipri_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_cause_i[DMA_HIPRI] && mask_q[BIT_RX_SUM] && !reg_we_i) |=> irq_o);

  assert_rx_summary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(dma_cause_i & DMA_RX_MASK)) |=> stat_q[BIT_RX_SUM]);

  assert_err_summary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_cause_i[DMA_ERR] |=> stat_q[BIT_ERR_SUM]);

  assert_periodic_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_q[BIT_PERIODIC]) && !$past(hw_cause_i[BIT_PERIODIC])) |-> ($past(per_q) != '0));
endmodule

// File: tb/irq_coalesce_top_tb.sv
module irq_coalesce_top_tb;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] hw = '0;
  logic [31:0] dma = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_coalesce_top #(.TICK_DIV(DIV)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .hw_cause_i  (hw),
    .dma_cause_i (dma),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_stat, m_mask, m_dma;
  logic [7:0]  m_coal, m_per;
  int          m_pre, m_pcnt, m_ccnt;
  bit          m_exp, m_prev;

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_per, m_coal};
      2'd1: return m_stat;
      2'd2: return m_mask;
      default: return m_dma;
    endcase
  endfunction

  function automatic bit m_irq();
    return ((m_stat & m_mask) != 0) && (m_coal == 0 || m_exp || m_dma[30]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_dma = '0; m_coal = 8'h40; m_per = 8'h00;
      m_pre = 0; m_pcnt = 0; m_ccnt = 0; m_exp = 0; m_prev = 0;
    end else begin
      bit tick, any, pev;
      logic [31:0] dev, set;
      tick = (m_pre == DIV - 1);
      any  = (m_stat & m_mask) != 0;
      pev  = (m_per != 0) && tick && (m_pcnt + 1 >= m_per);
      if ((we && addr == 2'd0) || m_per == 0) m_pcnt = 0;
      else if (tick) m_pcnt = pev ? 0 : m_pcnt + 1;
      if ((any && !m_prev) || !any) begin m_ccnt = 0; m_exp = 0; end
      else if (!m_exp && tick) begin
        if (m_ccnt + 1 >= m_coal) m_exp = 1; else m_ccnt = m_ccnt + 1;
      end
      m_prev = any;
      dev = dma & 32'hC003_0003;
      set = hw;
      if (dev[16] || dev[17] || dev[30]) set[31] = 1'b1;
      if (dev[0] || dev[1]) set[27] = 1'b1;
      if (dev[31]) set[29] = 1'b1;
      if (pev) set[28] = 1'b1;
      m_stat = (m_stat & ~((we && addr == 2'd1) ? wdata : 32'h0)) | set;
      m_dma  = (m_dma  & ~((we && addr == 2'd3) ? wdata : 32'h0)) | dev;
      if (we && addr == 2'd2) m_mask = wdata;
      if (we && addr == 2'd0) begin m_coal = wdata[7:0]; m_per = wdata[15:8]; end
      m_pre = tick ? 0 : m_pre + 1;
    end
    #1;
    if (rst_n) begin
      chk("R8 model irq", {31'h0, irq}, {31'h0, m_irq()});
      chk("R11 model rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] h, input logic [31:0] q);
    @(negedge clk); hw = h; dma = q;
    @(negedge clk); hw = '0; dma = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0000_0040);
    rd(2'd1, v); chk("R1 stat", v, 32'h0);
    rd(2'd2, v); chk("R1 mask", v, 32'h0);
    rd(2'd3, v); chk("R1 dma",  v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R11 layout, upper bits ignored
    wr(2'd0, 32'hFFFF_0305); rd(2'd0, v); chk("R11 ctrl", v, 32'h0000_0305);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R11 mask", v, 32'hFFFF_FFFF);

    // R7 zero coalescing
    wr(2'd0, 32'h0);
    pulse(32'h1, 32'h0);
    chk("R7 immediate irq", {31'h0, irq}, 32'h1);

    // R2 write-one-to-clear
    wr(2'd1, 32'h2); rd(2'd1, v); chk("R2 zero keeps", v, 32'h1);
    wr(2'd1, 32'h1); rd(2'd1, v); chk("R2 one clears", v, 32'h0);
    chk("R2 irq drops", {31'h0, irq}, 32'h0);

    // R3 set wins over clear
    @(negedge clk); hw = 32'h8; we = 1'b1; addr = 2'd1; wdata = 32'h8;
    @(negedge clk); hw = '0; we = 1'b0; wdata = '0;
    rd(2'd1, v); chk("R3 set wins", v, 32'h8);
    wr(2'd1, 32'hFFFF_FFFF);

    // R4 / R5 DMA causes
    pulse(32'h0, 32'h0001_0000);
    rd(2'd3, v); chk("R4 rx0 latch", v, 32'h0001_0000);
    rd(2'd1, v); chk("R5 rx summary", v, 32'h8000_0000);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    pulse(32'h0, 32'h0000_0002);
    rd(2'd1, v); chk("R5 tx summary", v, 32'h0800_0000);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    pulse(32'h0, 32'h8000_0000);
    rd(2'd1, v); chk("R5 err summary", v, 32'h2000_0000);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    pulse(32'h0, 32'h0000_0020);
    rd(2'd3, v); chk("R4 invalid dropped", v, 32'h0);
    rd(2'd1, v); chk("R4 no summary", v, 32'h0);

    // R8 coalescing delay of 3 units
    wr(2'd0, 32'h0000_0003);
    pulse(32'h40, 32'h0);
    chk("R8 held back", {31'h0, irq}, 32'h0);
    idle(40);
    chk("R8 after delay", {31'h0, irq}, 32'h1);

    // R6 mask gates the line
    wr(2'd2, 32'h0);
    chk("R6 masked off", {31'h0, irq}, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);

    // R9 high-priority bypass
    wr(2'd0, 32'h0000_00FF);
    pulse(32'h0, 32'h4000_0000);
    chk("R9 bypass", {31'h0, irq}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);

    // R10 periodic
    wr(2'd2, 32'h1000_0000);
    wr(2'd0, 32'h0000_0200);
    idle(30);
    rd(2'd1, v); chk("R10 periodic set", v & 32'h1000_0000, 32'h1000_0000);
    chk("R10 periodic irq", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(100);
    rd(2'd1, v); chk("R10 disabled", v, 32'h0);

    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule